// File: doc/BRIEF.md
# DPLL Phase Lock/Loss Monitor

This block watches a digital PLL and decides whether it is in lock. It receives single-cycle strobes marking edges of the input reference clock and of the feedback clock. It also receives a signed fine phase-error word from the phase detector, a flag raised while the loop sits at its minimum or maximum frequency, and a flag raised when the input has gone quiet. A signed multi-cycle counter accumulates whole-cycle slips between the two clocks. That count is the phase position the loop must eventually pull back to, and it is tracked in every configuration.

Four loss sources feed one lock decision, and each has its own enable: the fine phase limit, the coarse slip range, the frequency limit and input inactivity. Loss takes effect at once. Lock is granted only after a programmable run of clean reference edges. The lock state selects the loop bandwidth code, either acquisition or locked, or the locked code when it is forced. It also drives a request for nearest-edge locking. All configuration arrives as static register-style fields.

Top module: `dpll_lock_monitor`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `locked`=0, `slip_pos`=0, `bw_code`=2 (70 Hz) and `nearest_req`=0.
- R2: `slip_pos` rises by 1 in the cycle after a cycle with only `ref_edge` set, falls by 1 after a cycle with only `fb_edge` set, and is unchanged when both or neither are set.
- R3: `slip_pos` saturates at +(2^(SLIP_W-1)-1) and -(2^(SLIP_W-1)-1). It never wraps and never takes the most negative code.
- R4: With the coarse source enabled and capture enabled, the coarse threshold for step field k is 2^k-1. Field values 0 and 14-15 clamp to k=1 and k=13. The coarse source is active when |`slip_pos`| exceeds the threshold.
- R5: With capture disabled, the coarse threshold is 0, so any nonzero slip count raises coarse loss when the coarse source is enabled. `slip_pos` keeps counting.
- R6: The fine source is active when `cfg_fine_en`=1 and |`fine_err`| > `cfg_fine_range`. An error equal to the range is not a loss.
- R7: `at_freq_limit` and `no_activity` cause loss only when `cfg_freqlim_en` and `cfg_activity_en` respectively are 1. Otherwise they have no effect.
- R8: When any enabled source is active in a cycle, `locked` is 0 after that clock edge.
- R9: `locked` rises on the clock edge of the N-th consecutive reference edge in which all enabled sources are clear, with N = max(`cfg_lock_count`,1). Any loss cycle restarts the run, and `locked` never rises without a reference edge.
- R10: `bw_code` is registered. It holds the locked code when `cfg_force_lbw`=1 or the next lock state is locked, and the acquisition code otherwise. Codes are 0=18 Hz, 1=35 Hz, 2=70 Hz, and an input code of 3 is emitted as 2.
- R11: `nearest_req` is registered and equals the next lock state OR'd with capture being disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_edge | input | 1 | Reference clock edge strobe |
| fb_edge | input | 1 | Feedback clock edge strobe |
| fine_err | input | FINE_W | Signed fine phase error |
| at_freq_limit | input | 1 | Loop at min or max frequency |
| no_activity | input | 1 | Input activity timeout |
| cfg_fine_en | input | 1 | Fine loss source enable |
| cfg_fine_range | input | 3 | Fine loss limit, 0..7 |
| cfg_coarse_en | input | 1 | Coarse slip loss source enable |
| cfg_capture_en | input | 1 | Multi-cycle capture enable |
| cfg_coarse_step | input | 4 | Coarse range step, 1..13 |
| cfg_freqlim_en | input | 1 | Frequency-limit source enable |
| cfg_activity_en | input | 1 | Inactivity source enable |
| cfg_lock_count | input | CNT_W | Clean reference edges needed to lock |
| cfg_force_lbw | input | 1 | Force locked bandwidth |
| cfg_locked_bw | input | 2 | Locked bandwidth code |
| cfg_acq_bw | input | 2 | Acquisition bandwidth code |
| slip_pos | output | SLIP_W | Signed whole-cycle slip count |
| locked | output | 1 | Lock state |
| bw_code | output | 2 | Selected bandwidth code |
| nearest_req | output | 1 | Nearest-edge locking request |

## Verification
The bench targets the off-by-one points: a fine error equal to its range, and a slip count equal to the coarse threshold against one beyond it. A design using >= in place of > would drop lock one unit early. It drives the step field to 0 and to 15 to expose a decoder that does not clamp, which would yield a zero or wrapped threshold. It also drives the counter into both saturation limits, where a missing guard wraps the sign. The lock run is interrupted midway to catch a qualifier that does not restart its count. Simultaneous edges are applied to catch a counter that favours one strobe over the other.

// File: rtl/lockmon_pkg.sv
package lockmon_pkg;

  typedef enum logic [1:0] {
    BW_18HZ = 2'd0,
    BW_35HZ = 2'd1,
    BW_70HZ = 2'd2
  } bw_code_e;

  localparam logic [3:0] STEP_LO = 4'd1;
  localparam logic [3:0] STEP_HI = 4'd13;

  typedef struct packed {
    logic fine;
    logic coarse;
    logic freq_lim;
    logic idle;
  } loss_vec_t;

  function automatic logic [1:0] legal_bw(input logic [1:0] code);
    return (code == 2'd3) ? BW_70HZ : code;
  endfunction

endpackage

// File: rtl/lockmon_slip_ctr.sv
module lockmon_slip_ctr #(
  parameter int SLIP_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ref_edge,
  input  logic                     fb_edge,
  output logic signed [SLIP_W-1:0] slip
);
  localparam logic signed [SLIP_W-1:0] POS_LIM = {1'b0, {(SLIP_W-1){1'b1}}};
  localparam logic signed [SLIP_W-1:0] NEG_LIM = -POS_LIM;
  localparam logic signed [SLIP_W-1:0] ONE     = 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      slip <= '0;
    end else if (ref_edge && !fb_edge && slip != POS_LIM) begin
      slip <= slip + ONE;
    end else if (fb_edge && !ref_edge && slip != NEG_LIM) begin
      slip <= slip - ONE;
    end
  end
endmodule

// File: rtl/lockmon_loss_merge.sv
module lockmon_loss_merge
  import lockmon_pkg::*;
#(
  parameter int SLIP_W = 16,
  parameter int FINE_W = 8
) (
  input  logic signed [SLIP_W-1:0] slip,
  input  logic signed [FINE_W-1:0] fine_err,
  input  logic                     at_freq_limit,
  input  logic                     no_activity,
  input  logic                     cfg_fine_en,
  input  logic [2:0]               cfg_fine_range,
  input  logic                     cfg_coarse_en,
  input  logic                     cfg_capture_en,
  input  logic [3:0]               cfg_coarse_step,
  input  logic                     cfg_freqlim_en,
  input  logic                     cfg_activity_en,
  output logic                     loss_any
);
  // SLIP_W must exceed 14 so the widest threshold (8191) fits below the limit.
  localparam logic [SLIP_W-1:0] U_ONE = 1;
  localparam logic [FINE_W:0]   F_ONE = 1;

  logic [3:0]        step_eff;
  logic [SLIP_W-1:0] thr_full;
  logic [SLIP_W-1:0] thr_used;
  logic [SLIP_W-1:0] slip_mag;
  logic [FINE_W:0]   fine_ext;
  logic [FINE_W:0]   fine_mag;
  logic [FINE_W:0]   range_ext;
  loss_vec_t         src;

  always_comb begin
    if (cfg_coarse_step < STEP_LO)      step_eff = STEP_LO;
    else if (cfg_coarse_step > STEP_HI) step_eff = STEP_HI;
    else                                step_eff = cfg_coarse_step;
  end

  assign thr_full  = (U_ONE << step_eff) - U_ONE;
  assign thr_used  = cfg_capture_en ? thr_full : '0;
  assign slip_mag  = slip[SLIP_W-1] ? (~slip + U_ONE) : slip;

  assign fine_ext  = {fine_err[FINE_W-1], fine_err};
  assign fine_mag  = fine_ext[FINE_W] ? (~fine_ext + F_ONE) : fine_ext;
  assign range_ext = {{(FINE_W-2){1'b0}}, cfg_fine_range};

  assign src.fine     = cfg_fine_en && (fine_mag > range_ext);
  assign src.coarse   = cfg_coarse_en && (slip_mag > thr_used);
  assign src.freq_lim = cfg_freqlim_en && at_freq_limit;
  assign src.idle     = cfg_activity_en && no_activity;

  assign loss_any = |src;
endmodule

// File: rtl/lockmon_lock_qual.sv
module lockmon_lock_qual #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_edge,
  input  logic             loss_any,
  input  logic [CNT_W-1:0] lock_count,
  output logic             lock_next,
  output logic             locked
);
  localparam logic [CNT_W-1:0] C_ONE = 1;
  localparam logic [CNT_W:0]   W_ONE = 1;

  logic [CNT_W-1:0] clean_cnt;
  logic [CNT_W-1:0] cnt_next;
  logic [CNT_W-1:0] target;
  logic [CNT_W:0]   run_inc;

  assign target  = (lock_count == '0) ? C_ONE : lock_count;
  assign run_inc = {1'b0, clean_cnt} + W_ONE;

  always_comb begin
    lock_next = locked;
    cnt_next  = clean_cnt;
    if (loss_any) begin
      lock_next = 1'b0;
      cnt_next  = '0;
    end else if (!locked && ref_edge) begin
      if (run_inc >= {1'b0, target}) lock_next = 1'b1;
      else                            cnt_next  = run_inc[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked    <= 1'b0;
      clean_cnt <= '0;
    end else begin
      locked    <= lock_next;
      clean_cnt <= cnt_next;
    end
  end
endmodule

// File: rtl/dpll_lock_monitor.sv
module dpll_lock_monitor
  import lockmon_pkg::*;
#(
  parameter int SLIP_W = 16,
  parameter int FINE_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ref_edge,
  input  logic                     fb_edge,
  input  logic signed [FINE_W-1:0] fine_err,
  input  logic                     at_freq_limit,
  input  logic                     no_activity,
  input  logic                     cfg_fine_en,
  input  logic [2:0]               cfg_fine_range,
  input  logic                     cfg_coarse_en,
  input  logic                     cfg_capture_en,
  input  logic [3:0]               cfg_coarse_step,
  input  logic                     cfg_freqlim_en,
  input  logic                     cfg_activity_en,
  input  logic [CNT_W-1:0]         cfg_lock_count,
  input  logic                     cfg_force_lbw,
  input  logic [1:0]               cfg_locked_bw,
  input  logic [1:0]               cfg_acq_bw,
  output logic signed [SLIP_W-1:0] slip_pos,
  output logic                     locked,
  output logic [1:0]               bw_code,
  output logic                     nearest_req
);
  logic loss_any;
  logic lock_next;

  lockmon_slip_ctr #(.SLIP_W(SLIP_W)) u_slip (
    .clk      (clk),
    .rst      (rst),
    .ref_edge (ref_edge),
    .fb_edge  (fb_edge),
    .slip     (slip_pos)
  );

  lockmon_loss_merge #(.SLIP_W(SLIP_W), .FINE_W(FINE_W)) u_merge (
    .slip            (slip_pos),
    .fine_err        (fine_err),
    .at_freq_limit   (at_freq_limit),
    .no_activity     (no_activity),
    .cfg_fine_en     (cfg_fine_en),
    .cfg_fine_range  (cfg_fine_range),
    .cfg_coarse_en   (cfg_coarse_en),
    .cfg_capture_en  (cfg_capture_en),
    .cfg_coarse_step (cfg_coarse_step),
    .cfg_freqlim_en  (cfg_freqlim_en),
    .cfg_activity_en (cfg_activity_en),
    .loss_any        (loss_any)
  );

  lockmon_lock_qual #(.CNT_W(CNT_W)) u_qual (
    .clk        (clk),
    .rst        (rst),
    .ref_edge   (ref_edge),
    .loss_any   (loss_any),
    .lock_count (cfg_lock_count),
    .lock_next  (lock_next),
    .locked     (locked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bw_code     <= BW_70HZ;
      nearest_req <= 1'b0;
    end else begin
      bw_code     <= (cfg_force_lbw || lock_next) ? legal_bw(cfg_locked_bw)
                                                  : legal_bw(cfg_acq_bw);
      nearest_req <= lock_next || !cfg_capture_en;
    end
  end
endmodule

// File: rtl/lockmon_checker.sv
module lockmon_checker #(
  parameter int SLIP_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     ref_edge,
  input logic                     fb_edge,
  input logic                     cfg_capture_en,
  input logic                     cfg_coarse_en,
  input logic                     cfg_force_lbw,
  input logic [1:0]               cfg_locked_bw,
  input logic signed [SLIP_W-1:0] slip_pos,
  input logic                     locked,
  input logic [1:0]               bw_code,
  input logic                     nearest_req,
  input logic                     loss_any
);
  localparam logic [SLIP_W-1:0] MOST_NEG = {1'b1, {(SLIP_W-1){1'b0}}};

  AST_SLIP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ref_edge == fb_edge) |=> $stable(slip_pos)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    slip_pos != MOST_NEG); // R3
  AST_NO_CAPTURE_LOSS: assert property (@(posedge clk) disable iff (rst)
    (!cfg_capture_en && cfg_coarse_en && slip_pos != '0) |-> loss_any); // R5
  AST_LOSS_DROPS: assert property (@(posedge clk) disable iff (rst)
    loss_any |=> !locked); // R8
  AST_LOCK_NEEDS_REF: assert property (@(posedge clk) disable iff (rst)
    (!locked && !ref_edge) |=> !locked); // R9
  AST_FORCED_BW: assert property (@(posedge clk) disable iff (rst)
    cfg_force_lbw |=> bw_code == (($past(cfg_locked_bw) == 2'd3) ? 2'd2 : $past(cfg_locked_bw))); // R10
  AST_BW_LEGAL: assert property (@(posedge clk) disable iff (rst)
    bw_code != 2'd3); // R10
  AST_NEAREST_NOCAP: assert property (@(posedge clk) disable iff (rst)
    !cfg_capture_en |=> nearest_req); // R11
endmodule

bind dpll_lock_monitor lockmon_checker #(.SLIP_W(SLIP_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .ref_edge       (ref_edge),
  .fb_edge        (fb_edge),
  .cfg_capture_en (cfg_capture_en),
  .cfg_coarse_en  (cfg_coarse_en),
  .cfg_force_lbw  (cfg_force_lbw),
  .cfg_locked_bw  (cfg_locked_bw),
  .slip_pos       (slip_pos),
  .locked         (locked),
  .bw_code        (bw_code),
  .nearest_req    (nearest_req),
  .loss_any       (loss_any)
);

// File: tb/dpll_lock_monitor_bench.sv
module dpll_lock_monitor_bench;
  localparam int SLIP_W = 16;
  localparam int FINE_W = 8;
  localparam int CNT_W  = 8;
  // {enable, range[2:0], error[7:0], expect_loss}
  localparam int NVEC = 8;
  localparam logic [12:0] FINE_VEC [NVEC] = '{
    {1'b1, 3'd3, 8'h03, 1'b0},
    {1'b1, 3'd3, 8'h04, 1'b1},
    {1'b1, 3'd3, 8'hFC, 1'b1},
    {1'b1, 3'd3, 8'hFD, 1'b0},
    {1'b1, 3'd0, 8'h01, 1'b1},
    {1'b1, 3'd7, 8'h80, 1'b1},
    {1'b0, 3'd0, 8'h7F, 1'b0},
    {1'b1, 3'd7, 8'h07, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_edge = 0, fb_edge = 0;
  logic signed [FINE_W-1:0] fine_err = '0;
  logic at_freq_limit = 0, no_activity = 0;
  logic cfg_fine_en = 1;
  logic [2:0] cfg_fine_range = 3'd7;
  logic cfg_coarse_en = 1, cfg_capture_en = 1;
  logic [3:0] cfg_coarse_step = 4'd13;
  logic cfg_freqlim_en = 1, cfg_activity_en = 1;
  logic [CNT_W-1:0] cfg_lock_count = 8'd1;
  logic cfg_force_lbw = 0;
  logic [1:0] cfg_locked_bw = 2'd1, cfg_acq_bw = 2'd2;
  logic signed [SLIP_W-1:0] slip_pos;
  logic locked, nearest_req;
  logic [1:0] bw_code;

  int checks = 0, failures = 0, cycles = 0;
  logic done = 0;

  always #10 clk = ~clk;

  dpll_lock_monitor #(.SLIP_W(SLIP_W), .FINE_W(FINE_W), .CNT_W(CNT_W)) u_dpll_lock_monitor (
    .clk(clk), .rst(rst), .ref_edge(ref_edge), .fb_edge(fb_edge), .fine_err(fine_err),
    .at_freq_limit(at_freq_limit), .no_activity(no_activity), .cfg_fine_en(cfg_fine_en),
    .cfg_fine_range(cfg_fine_range), .cfg_coarse_en(cfg_coarse_en),
    .cfg_capture_en(cfg_capture_en), .cfg_coarse_step(cfg_coarse_step),
    .cfg_freqlim_en(cfg_freqlim_en), .cfg_activity_en(cfg_activity_en),
    .cfg_lock_count(cfg_lock_count), .cfg_force_lbw(cfg_force_lbw),
    .cfg_locked_bw(cfg_locked_bw), .cfg_acq_bw(cfg_acq_bw), .slip_pos(slip_pos),
    .locked(locked), .bw_code(bw_code), .nearest_req(nearest_req)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse(input logic r, input logic f);
    ref_edge = r;
    fb_edge  = f;
    tick();
    ref_edge = 0;
    fb_edge  = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    tick();
    rst = 0;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 180000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 180000);
        finish_run();
      end
    end
  end

  initial begin
    // R1 reset state, with configuration that would otherwise differ
    cfg_capture_en = 0;
    tick(); tick();
    check("R1 locked", int'(locked), 0);
    check("R1 slip", int'(slip_pos), 0);
    check("R1 bw", int'(bw_code), 2);
    check("R1 nearest", int'(nearest_req), 0);
    cfg_capture_en = 1;
    rst = 0;

    // R2 counting
    pulse(1, 0); check("R2 ref only", int'(slip_pos), 1);
    pulse(1, 1); check("R2 both cancel", int'(slip_pos), 1);
    pulse(0, 1); check("R2 fb only", int'(slip_pos), 0);
    pulse(0, 1); check("R2 below zero", int'(slip_pos), -1);

    // R6 fine-limit table
    for (int i = 0; i < NVEC; i++) begin
      do_reset();
      fine_err = '0; cfg_fine_en = 1; cfg_fine_range = 3'd7;
      pulse(1, 1);
      check("R6 relock", int'(locked), 1);
      cfg_fine_en    = FINE_VEC[i][12];
      cfg_fine_range = FINE_VEC[i][11:9];
      fine_err       = FINE_VEC[i][8:1];
      tick();
      check("R6 fine vector", int'(locked), int'(!FINE_VEC[i][0]));
      fine_err = '0; cfg_fine_en = 1; cfg_fine_range = 3'd7;
    end

    // R9 / R10 / R11 lock run of four edges
    cfg_lock_count = 8'd4;
    do_reset();
    pulse(1, 1); pulse(1, 1); pulse(1, 1);
    check("R9 not yet locked", int'(locked), 0);
    check("R10 acq bw while unlocked", int'(bw_code), 2);
    check("R11 no request unlocked", int'(nearest_req), 0);
    pulse(1, 1);
    check("R9 locked at 4th edge", int'(locked), 1);
    check("R10 locked bw", int'(bw_code), 1);
    check("R11 request when locked", int'(nearest_req), 1);
    do_reset();
    pulse(1, 1); pulse(1, 1);
    at_freq_limit = 1; tick(); at_freq_limit = 0;
    pulse(1, 1); pulse(1, 1); pulse(1, 1);
    check("R9 run restarted", int'(locked), 0);
    pulse(1, 1);
    check("R9 locked after fresh run", int'(locked), 1);
    cfg_lock_count = 8'd1;

    // R7 enables of frequency-limit and inactivity
    do_reset(); pulse(1, 1);
    cfg_activity_en = 0; no_activity = 1; tick();
    check("R7 inactivity masked", int'(locked), 1);
    cfg_activity_en = 1; tick();
    check("R7 inactivity loss", int'(locked), 0);
    no_activity = 0;
    cfg_freqlim_en = 0; at_freq_limit = 1; pulse(1, 1);
    check("R7 freq limit masked", int'(locked), 1);
    cfg_freqlim_en = 1; tick();
    check("R7 freq limit loss", int'(locked), 0);
    at_freq_limit = 0;

    // R4 / R8 coarse threshold step 2 -> 3
    cfg_coarse_step = 4'd2;
    do_reset();
    pulse(1, 0); pulse(1, 0); pulse(1, 0);
    check("R4 slip at threshold", int'(slip_pos), 3);
    check("R4 locked at threshold", int'(locked), 1);
    pulse(1, 0);
    check("R8 still locked same edge", int'(locked), 1);
    tick();
    check("R8 loss one edge later", int'(locked), 0);
    pulse(0, 1); pulse(1, 1);
    check("R4 relock inside range", int'(locked), 1);

    // R4 clamp low: field 0 -> threshold 1
    cfg_coarse_step = 4'd0;
    do_reset();
    pulse(1, 0);
    check("R4 clamp0 locked at 1", int'(locked), 1);
    pulse(1, 0); tick();
    check("R4 clamp0 loss at 2", int'(locked), 0);

    // R4 clamp high: field 15 -> threshold 8191
    cfg_coarse_step = 4'd15;
    do_reset();
    for (int i = 0; i < 8191; i++) pulse(0, 1);
    pulse(1, 1);
    check("R4 clamp15 locked at -8191", int'(locked), 1);
    pulse(0, 1); tick();
    check("R4 clamp15 loss at -8192", int'(locked), 0);
    cfg_coarse_step = 4'd13;

    // R5 capture disabled
    cfg_capture_en = 0;
    do_reset();
    tick();
    check("R11 request without capture", int'(nearest_req), 1);
    pulse(1, 0); pulse(1, 1);
    check("R5 slip still tracks", int'(slip_pos), 1);
    check("R5 one slip is loss", int'(locked), 0);
    pulse(0, 1); pulse(1, 1);
    check("R5 locks at zero slip", int'(locked), 1);
    cfg_capture_en = 1;

    // R3 saturation both ways
    cfg_coarse_en = 0;
    do_reset();
    for (int i = 0; i < 32770; i++) pulse(1, 0);
    check("R3 positive limit", int'(slip_pos), 32767);
    pulse(0, 1);
    check("R3 leaves limit", int'(slip_pos), 32766);
    do_reset();
    for (int i = 0; i < 32770; i++) pulse(0, 1);
    check("R3 negative limit", int'(slip_pos), -32767);
    cfg_coarse_en = 1;

    // R10 forced and clamped codes
    do_reset();
    cfg_force_lbw = 1; tick();
    check("R10 forced locked bw", int'(bw_code), 1);
    cfg_force_lbw = 0; cfg_acq_bw = 2'd3; tick();
    check("R10 code 3 emitted as 2", int'(bw_code), 2);
    cfg_acq_bw = 2'd0; tick();
    check("R10 acq 18 Hz", int'(bw_code), 0);

    finish_run();
  end
endmodule